// File: doc/BRIEF.md
# Two-Channel Fly-By DMA Engine

This block holds a pair of independent DMA channels that move data between system memory and peripherals without ever holding the data themselves. Each transfer is one bus cycle. The block drives the memory address and the direction of the memory access. In the same cycle it strobes the acknowledge line of the peripheral being served, so the data passes straight from the memory to the peripheral, or the other way.

Each channel is armed by a one-cycle load strobe. The strobe captures a first address, a final address, a direction and a throttle limit, and it sets the channel's enable bit. An armed channel then runs in one of two ways. While its request pin is high it is served one transfer per handshake. After a software start pulse it runs unattended until the final address. The engine asks for the shared bus with a request/grant pair. While it holds the grant it issues one transfer per cycle. When both channels want service, channel 0 wins. A non-zero throttle limit makes a channel give up the bus after that many transfers. That channel then stays silent until the processor has been granted the bus at least once.

Top module: `flyby_dma`

## Requirements
- R1: After reset, `bus_req`, `mem_valid`, `dack`, `eop` and `ch_en` are all zero.
- R2: An armed channel issues transfers at its first address and then at addresses one higher each, in order, up to and including its final address.
- R3: `mem_valid` is high for exactly one cycle per transfer, and in that cycle exactly one `dack` bit is high, the one of the channel served (bit 0 = channel 0). `dack` is never high without `mem_valid`.
- R4: `eop` of a channel is high only together with that channel's `dack`, on the transfer to its final address. In that same cycle the channel's `ch_en` bit goes low.
- R5: `mem_wr` equals the direction the channel was loaded with: 1 means peripheral-to-memory (memory write), 0 means memory-to-peripheral.
- R6: While an armed channel's request pin is held high until its `dack` is seen and then dropped, exactly one transfer takes place per handshake. A request pin on a disabled channel raises no `bus_req` and causes no transfer.
- R7: A software start pulse on a disabled channel is discarded: loading that channel later does not start it.
- R8: A transfer is issued only in a cycle after `bus_gnt` was high. While `bus_gnt` is withheld, `bus_req` stays high and no transfer occurs.
- R9: When both channels are ready at once, channel 0 is served first. Channel 1 follows without the bus being released.
- R10: With throttle limit T > 0, a channel issues at most T transfers per bus tenure and then drops `bus_req`. T = 0 means no limit.
- R11: A channel that gave up the bus because of its throttle does not request the bus again until `cpu_gnt` has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 2 | Per-channel strobe: capture configuration and arm |
| cfg_start | input | 2 x ADDR_W | First transfer address per channel |
| cfg_stop | input | 2 x ADDR_W | Final transfer address per channel |
| cfg_dir | input | 2 | Direction per channel, 1 = peripheral-to-memory |
| cfg_thr | input | 2 x THR_W | Throttle limit per channel, 0 = unlimited |
| sw_go | input | 2 | Software start pulse per channel |
| dreq | input | 2 | Peripheral request pins |
| bus_gnt | input | 1 | Bus granted to this engine |
| cpu_gnt | input | 1 | Bus granted to the processor |
| bus_req | output | 1 | Bus request from this engine |
| mem_valid | output | 1 | Fly-by transfer cycle strobe |
| mem_addr | output | ADDR_W | Memory address of the current transfer |
| mem_wr | output | 1 | Memory write (1) or read (0) |
| dack | output | 2 | Peripheral acknowledge per channel |
| eop | output | 2 | End-of-process pulse per channel |
| ch_en | output | 2 | Channel enable bits |

## Verification
Some rules hold on every cycle, and the bound assertions check those: `dack` is one-hot or zero and is never high without `mem_valid`, `eop` comes with its own channel's `dack` and clears `ch_en`, no transfer happens without a prior grant, and the address climbs by one between back-to-back transfers of one channel. Other behaviour plays out over whole runs, so only the directed scenarios can show it. That covers the fixed priority order, the number of transfers per bus tenure under a throttle, the wait for a processor grant before asking again, and software starts being dropped on a disabled channel.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_ASK  = 2'd1,
        ARB_OWN  = 2'd2,
        ARB_GIVE = 2'd3
    } arb_state_t;

    typedef struct packed {
        logic           valid;
        logic           wr;
        logic [NCH-1:0] ack;
        logic [NCH-1:0] last;
    } xfer_ctl_t;

    // Lowest-numbered requester wins.
    function automatic logic [NCH-1:0] pick_first(input logic [NCH-1:0] req);
        pick_first = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_first    = '0;
                pick_first[i] = 1'b1;
            end
        end
    endfunction

endpackage

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int THR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_stop,
    input  logic              cfg_dir,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic              sw_go,
    input  logic              dreq,
    input  logic              cpu_gnt,
    input  logic              tenure_end,
    input  logic              issue,
    output logic              want,
    output logic              at_last,
    output logic              thr_hit,
    output logic              dir,
    output logic              en,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam logic [THR_W-1:0] THR_ONE = THR_W'(1);

    logic              en_q;
    logic              pend_q;
    logic              hold_q;
    logic              dir_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] stop_q;
    logic [THR_W-1:0]  lim_q;
    logic [THR_W-1:0]  cnt_q;

    assign at_last  = (cur_q == stop_q);
    assign thr_hit  = (lim_q != '0) && (cnt_q == lim_q - THR_ONE);
    assign want     = en_q && !hold_q && (dreq || pend_q);
    assign dir      = dir_q;
    assign en       = en_q;
    assign cur_addr = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            hold_q <= 1'b0;
            dir_q  <= 1'b0;
            cur_q  <= '0;
            stop_q <= '0;
            lim_q  <= '0;
            cnt_q  <= '0;
        end else if (cfg_load) begin
            en_q   <= 1'b1;
            pend_q <= 1'b0;
            hold_q <= 1'b0;
            dir_q  <= cfg_dir;
            cur_q  <= cfg_start;
            stop_q <= cfg_stop;
            lim_q  <= cfg_thr;
            cnt_q  <= '0;
        end else begin
            // software start only latches on an armed channel
            if (sw_go && en_q) begin
                pend_q <= 1'b1;
            end
            if (issue) begin
                if (at_last) begin
                    en_q   <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    cur_q <= cur_q + ADDR_W'(1);
                end
            end
            if (issue && thr_hit) begin
                cnt_q  <= '0;
                hold_q <= 1'b1;
            end else begin
                if (tenure_end) begin
                    cnt_q <= '0;
                end else if (issue) begin
                    cnt_q <= cnt_q + THR_ONE;
                end
                if (cpu_gnt) begin
                    hold_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/flyby_dma_arb.sv
module flyby_dma_arb
    import flyby_dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] want,
    input  logic [NCH-1:0] thr_hit,
    input  logic           bus_gnt,
    output logic           bus_req,
    output logic [NCH-1:0] issue,
    output logic           tenure_end
);

    arb_state_t     state_q;
    arb_state_t     state_d;
    logic [NCH-1:0] winner;
    logic           any_want;
    logic           winner_hit;

    assign any_want   = |want;
    assign winner     = pick_first(want);
    assign winner_hit = |(winner & thr_hit);
    assign bus_req    = (state_q == ARB_ASK) || (state_q == ARB_OWN);

    always_comb begin
        state_d    = state_q;
        issue      = '0;
        tenure_end = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (any_want) state_d = ARB_ASK;
            end
            ARB_ASK: begin
                if (bus_gnt) state_d = ARB_OWN;
            end
            ARB_OWN: begin
                if (!bus_gnt) begin
                    state_d    = ARB_ASK;
                    tenure_end = 1'b1;
                end else if (any_want) begin
                    issue = winner;
                    if (winner_hit) begin
                        state_d    = ARB_GIVE;
                        tenure_end = 1'b1;
                    end
                end else begin
                    state_d    = ARB_GIVE;
                    tenure_end = 1'b1;
                end
            end
            ARB_GIVE: begin
                if (!bus_gnt) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/flyby_dma_xfer.sv
module flyby_dma_xfer
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             issue,
    input  logic [NCH-1:0]             at_last,
    input  logic [NCH-1:0]             dir,
    input  logic [NCH-1:0][ADDR_W-1:0] cur_addr,
    output logic                       mem_valid,
    output logic                       mem_wr,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [NCH-1:0]             dack,
    output logic [NCH-1:0]             eop
);

    xfer_ctl_t         ctl_d;
    xfer_ctl_t         ctl_q;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        addr_d    = addr_q;
        ctl_d     = '0;
        ctl_d.ack = issue;
        ctl_d.last = issue & at_last;
        ctl_d.valid = |issue;
        for (int i = 0; i < NCH; i++) begin
            if (issue[i]) begin
                addr_d   = cur_addr[i];
                ctl_d.wr = dir[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            addr_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            addr_q <= addr_d;
        end
    end

    assign mem_valid = ctl_q.valid;
    assign mem_wr    = ctl_q.wr;
    assign mem_addr  = addr_q;
    assign dack      = ctl_q.ack;
    assign eop       = ctl_q.last;

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int THR_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             cfg_load,
    input  logic [NCH-1:0][ADDR_W-1:0] cfg_start,
    input  logic [NCH-1:0][ADDR_W-1:0] cfg_stop,
    input  logic [NCH-1:0]             cfg_dir,
    input  logic [NCH-1:0][THR_W-1:0]  cfg_thr,
    input  logic [NCH-1:0]             sw_go,
    input  logic [NCH-1:0]             dreq,
    input  logic                       bus_gnt,
    input  logic                       cpu_gnt,
    output logic                       bus_req,
    output logic                       mem_valid,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_wr,
    output logic [NCH-1:0]             dack,
    output logic [NCH-1:0]             eop,
    output logic [NCH-1:0]             ch_en
);

    logic [NCH-1:0]             want;
    logic [NCH-1:0]             at_last;
    logic [NCH-1:0]             thr_hit;
    logic [NCH-1:0]             dir;
    logic [NCH-1:0]             issue;
    logic [NCH-1:0][ADDR_W-1:0] cur_addr;
    logic                       tenure_end;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        flyby_dma_chan #(
            .ADDR_W(ADDR_W),
            .THR_W (THR_W)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg_load  (cfg_load[c]),
            .cfg_start (cfg_start[c]),
            .cfg_stop  (cfg_stop[c]),
            .cfg_dir   (cfg_dir[c]),
            .cfg_thr   (cfg_thr[c]),
            .sw_go     (sw_go[c]),
            .dreq      (dreq[c]),
            .cpu_gnt   (cpu_gnt),
            .tenure_end(tenure_end),
            .issue     (issue[c]),
            .want      (want[c]),
            .at_last   (at_last[c]),
            .thr_hit   (thr_hit[c]),
            .dir       (dir[c]),
            .en        (ch_en[c]),
            .cur_addr  (cur_addr[c])
        );
    end

    flyby_dma_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .thr_hit   (thr_hit),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .issue     (issue),
        .tenure_end(tenure_end)
    );

    flyby_dma_xfer #(
        .ADDR_W(ADDR_W)
    ) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue),
        .at_last  (at_last),
        .dir      (dir),
        .cur_addr (cur_addr),
        .mem_valid(mem_valid),
        .mem_wr   (mem_wr),
        .mem_addr (mem_addr),
        .dack     (dack),
        .eop      (eop)
    );

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    cfg_load,
    input logic              bus_gnt,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NCH-1:0]    dack,
    input logic [NCH-1:0]    eop,
    input logic [NCH-1:0]    ch_en
);

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    assert_ack_in_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> mem_valid);

    assert_cycle_has_ack_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ($countones(dack) == 1));

    assert_eop_with_ack_R4: assert property (@(posedge clk) disable iff (rst)
        ((eop & ~dack) == '0));

    assert_eop_disables_R4: assert property (@(posedge clk) disable iff (rst)
        ((eop & ch_en) == '0));

    assert_needs_grant_R8: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> $past(bus_gnt));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && $past(mem_valid) && (dack == $past(dack)) && ($past(eop) == '0)
         && ($past(cfg_load) == '0) && ($past(cfg_load, 2) == '0))
        |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

bind flyby_dma flyby_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .bus_gnt  (bus_gnt),
    .mem_valid(mem_valid),
    .mem_addr (mem_addr),
    .dack     (dack),
    .eop      (eop),
    .ch_en    (ch_en)
);

// File: tb/flyby_dma_tb.sv
module flyby_dma_tb;

    localparam int AW = 16;
    localparam int TW = 6;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           cfg_load = '0;
    logic [1:0][AW-1:0]   cfg_start = '0;
    logic [1:0][AW-1:0]   cfg_stop = '0;
    logic [1:0]           cfg_dir = '0;
    logic [1:0][TW-1:0]   cfg_thr = '0;
    logic [1:0]           sw_go = '0;
    logic [1:0]           dreq = '0;
    logic                 bus_gnt = 1'b0;
    logic                 cpu_gnt;
    logic                 bus_req;
    logic                 mem_valid;
    logic [AW-1:0]        mem_addr;
    logic                 mem_wr;
    logic [1:0]           dack;
    logic [1:0]           eop;
    logic [1:0]           ch_en;

    logic gnt_allow = 1'b1;
    logic cpu_allow = 1'b1;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    flyby_dma #(.ADDR_W(AW), .THR_W(TW)) u_dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_start(cfg_start),
        .cfg_stop(cfg_stop), .cfg_dir(cfg_dir), .cfg_thr(cfg_thr), .sw_go(sw_go),
        .dreq(dreq), .bus_gnt(bus_gnt), .cpu_gnt(cpu_gnt), .bus_req(bus_req),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .dack(dack), .eop(eop), .ch_en(ch_en)
    );

    // simple external bus owner: grant follows request, processor owns it otherwise
    always @(negedge clk) bus_gnt <= !rst && bus_req && gnt_allow;
    assign cpu_gnt = !bus_gnt && cpu_allow;

    // transfer log
    logic [AW-1:0] l_addr [256];
    logic [1:0]    l_ack  [256];
    logic          l_wr   [256];
    logic [1:0]    l_eop  [256];
    int            l_ten  [256];
    int            n_log = 0;
    int            n_ten = 0;
    logic          gnt_prev = 1'b0;

    always @(negedge clk) begin
        if (bus_gnt && !gnt_prev) n_ten = n_ten + 1;
        gnt_prev = bus_gnt;
        if (mem_valid) begin
            l_addr[n_log[7:0]] = mem_addr;
            l_ack[n_log[7:0]]  = dack;
            l_wr[n_log[7:0]]   = mem_wr;
            l_eop[n_log[7:0]]  = eop;
            l_ten[n_log[7:0]]  = n_ten;
            n_log = n_log + 1;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int ch, input int first, input int last, input bit d, input int thr);
        @(negedge clk);
        cfg_start[ch] = AW'(first);
        cfg_stop[ch]  = AW'(last);
        cfg_dir[ch]   = d;
        cfg_thr[ch]   = TW'(thr);
        cfg_load[ch]  = 1'b1;
        @(negedge clk);
        cfg_load = '0;
    endtask

    task automatic go(input logic [1:0] m);
        @(negedge clk);
        sw_go = m;
        @(negedge clk);
        sw_go = '0;
    endtask

    // compare a run of logged transfers of one channel
    task automatic chk_run(input string tag, input int base, input int cnt, input int ch,
                           input int first, input bit d);
        for (int k = 0; k < cnt; k++) begin
            chk(tag, "dack", l_ack[base + k], (ch == 0) ? 1 : 2);
            chk("R2", "address", l_addr[base + k], first + k);
            chk("R5", "mem_wr", l_wr[base + k], d);
            chk("R4", "eop", l_eop[base + k], (k == cnt - 1) ? ((ch == 0) ? 1 : 2) : 0);
        end
    endtask

    task automatic t_reset;
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "mem_valid", mem_valid, 0);
        chk("R1", "dack", dack, 0);
        chk("R1", "eop", eop, 0);
        chk("R1", "ch_en", ch_en, 0);
    endtask

    task automatic t_priority;
        int base = n_log;
        load(0, 'h10, 'h13, 1'b0, 0);
        load(1, 'h20, 'h23, 1'b1, 0);
        chk("R2", "ch_en after load", ch_en, 3);
        go(2'b11);
        cycles(40);
        chk("R9", "transfer count", n_log - base, 8);
        chk_run("R9", base, 4, 0, 'h10, 1'b0);
        chk_run("R9", base + 4, 4, 1, 'h20, 1'b1);
        chk("R10", "one tenure when unlimited", l_ten[base + 7], l_ten[base]);
        chk("R4", "ch_en after end", ch_en, 0);
    endtask

    task automatic t_throttle;
        int base = n_log;
        load(0, 'h100, 'h10B, 1'b1, 4);
        go(2'b01);
        cycles(80);
        chk("R10", "transfer count", n_log - base, 12);
        chk_run("R3", base, 12, 0, 'h100, 1'b1);
        for (int g = 0; g < 3; g++) begin
            chk("R10", "same tenure in group", l_ten[base + 4*g + 3], l_ten[base + 4*g]);
            if (g > 0) chk("R10", "new tenure per group",
                           (l_ten[base + 4*g] != l_ten[base + 4*g - 1]) ? 1 : 0, 1);
        end
    endtask

    task automatic t_hold;
        int base = n_log;
        int req_seen = 0;
        cpu_allow = 1'b0;
        load(1, 'h300, 'h305, 1'b0, 2);
        go(2'b10);
        cycles(15);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bus_req) req_seen++;
        end
        chk("R11", "transfers before cpu grant", n_log - base, 2);
        chk("R11", "bus_req cycles while held", req_seen, 0);
        chk("R11", "still armed", ch_en[1], 1);
        cpu_allow = 1'b1;
        cycles(60);
        chk("R11", "transfers after cpu grant", n_log - base, 6);
        chk_run("R11", base, 6, 1, 'h300, 1'b0);
        chk("R4", "ch_en cleared", ch_en[1], 0);
    endtask

    task automatic t_dreq;
        int base = n_log;
        int waited;
        load(0, 'h40, 'h42, 1'b1, 0);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            dreq[0] = 1'b1;
            waited = 0;
            while (!dack[0] && waited < 50) begin
                @(negedge clk);
                waited++;
            end
            dreq[0] = 1'b0;
            cycles(6);
            chk("R6", "one transfer per handshake", n_log - base, h + 1);
        end
        chk_run("R6", base, 3, 0, 'h40, 1'b1);
        chk("R4", "ch_en after pin run", ch_en[0], 0);
    endtask

    task automatic t_ignore;
        int base = n_log;
        int req_seen = 0;
        dreq[0] = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bus_req) req_seen++;
        end
        dreq[0] = 1'b0;
        chk("R6", "bus_req on disabled pin", req_seen, 0);
        chk("R6", "transfers on disabled pin", n_log - base, 0);
        go(2'b10);
        cycles(5);
        load(1, 'h60, 'h60, 1'b1, 0);
        cycles(20);
        chk("R7", "start before arming discarded", n_log - base, 0);
        chk("R7", "bus_req stays low", bus_req, 0);
        chk("R7", "armed but idle", ch_en[1], 1);
        go(2'b10);
        cycles(20);
        chk("R7", "fresh start runs", n_log - base, 1);
        chk_run("R7", base, 1, 1, 'h60, 1'b1);
    endtask

    task automatic t_grant;
        int base = n_log;
        gnt_allow = 1'b0;
        load(0, 'h500, 'h501, 1'b0, 0);
        go(2'b01);
        cycles(20);
        chk("R8", "bus_req while waiting", bus_req, 1);
        chk("R8", "no transfer without grant", n_log - base, 0);
        gnt_allow = 1'b1;
        cycles(20);
        chk("R8", "transfers after grant", n_log - base, 2);
        chk_run("R8", base, 2, 0, 'h500, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_priority();
        t_throttle();
        t_hold();
        t_dreq();
        t_ignore();
        t_grant();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule